// File: doc/BRIEF.md
# DMA Physical Address Generator

This block produces the 24-bit physical memory address for a single DMA channel. It holds the channel's 16-bit current address counter, its 8-bit page value and its 16-bit transfer counter. After every completed transfer cycle it steps the address up or down and decrements the transfer counter. A channel-type input selects byte addressing or 16-bit word addressing. In word mode the counter is shifted left by one, address bit 0 is forced low and the lowest page bit is dropped. The counter never carries into the page. A transfer therefore stays inside a 64 KB window on byte channels and a 128 KB window on word channels.

Software loads the counter value, the page and the count through separate strobes. The count is the number of transfers minus one. The block raises a one-cycle terminal-count pulse when the transfer that moves the count from zero to all-ones has completed. A new page can be loaded on its own so that the next transfer starts in a different window while the counter keeps its low bits.

Top module: `dma_phys_addr_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `phys_addr` is 0 and `tc_pulse` is 0.
- R2: With `is_word`=0, `phys_addr[23:16]` equals the stored page and `phys_addr[15:0]` equals the address counter.
- R3: With `is_word`=1, `phys_addr[16:1]` equals the address counter, `phys_addr[0]` is 0 and `phys_addr[23:17]` equals stored page bits [7:1]. Page bit 0 has no effect on the output.
- R4: At each clock edge where `xfer_done`=1, `addr_load`=0 and `dec_mode`=0, the counter increments by one. 0xFFFF becomes 0x0000 and the page is unchanged.
- R5: At each clock edge where `xfer_done`=1, `addr_load`=0 and `dec_mode`=1, the counter decrements by one. 0x0000 becomes 0xFFFF and the page is unchanged.
- R6: A count N loaded with `cnt_load` makes `tc_pulse` high for exactly one cycle after the (N+1)-th accepted `xfer_done`. That transfer takes the count from 0x0000 to 0xFFFF, and counting continues from 0xFFFF.
- R7: `page_load` replaces the page on the next edge and leaves the address counter unchanged.
- R8: When `addr_load` or `cnt_load` coincides with `xfer_done`, the loaded value wins and no step is applied to that register.
- R9: `word_size` equals `is_word` (1 = 16-bit transfers, 0 = byte transfers).
- R10: Without `xfer_done` or a load, the address, page and count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_word | input | 1 | 1 = word channel, 0 = byte channel |
| dec_mode | input | 1 | 1 = address decrements per transfer |
| page_in | input | 8 | Page value to load |
| page_load | input | 1 | Load strobe for the page |
| addr_in | input | 16 | Counter value to load |
| addr_load | input | 1 | Load strobe for the address counter |
| cnt_in | input | 16 | Transfer count minus one |
| cnt_load | input | 1 | Load strobe for the transfer count |
| xfer_done | input | 1 | One transfer cycle completed |
| phys_addr | output | 24 | Physical memory address |
| word_size | output | 1 | Transfer size indicator |
| tc_pulse | output | 1 | Terminal-count pulse |

## Verification
The hardest state to reach is the counter wrapping at a window edge in the same run where the page changes. It must be shown that the page never absorbs a carry or borrow, in either direction and on both channel types. The stimulus loads the counter just below 0xFFFF or just above 0x0000 and steps it across the boundary. The same is done right after a standalone page reload. A further case lands a load strobe in the same cycle as a transfer-done pulse. A long stretch of random strobes then runs against a cycle-accurate behavioural model, with the count kept small so that terminal count is hit often.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_PAGE_W = 8;

    typedef enum logic {
        KIND_BYTE = 1'b0,
        KIND_WORD = 1'b1
    } chan_kind_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } step_dir_e;
endpackage

// File: rtl/dma_agen_stepper.sv
module dma_agen_stepper #(
    parameter int W = dma_agen_pkg::DEF_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [W-1:0]           load_val,
    input  logic                   step,
    input  dma_agen_pkg::step_dir_e dir,
    output logic [W-1:0]           q
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            if (dir == dma_agen_pkg::DIR_DOWN) q <= q - ONE;
            else                               q <= q + ONE;
        end
    end
endmodule

// File: rtl/dma_agen_tc.sv
module dma_agen_tc #(
    parameter int W = dma_agen_pkg::DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         tc
);
    logic [W-1:0] remain;
    logic         hit;

    dma_agen_stepper #(.W(W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .step     (step),
        .dir      (dma_agen_pkg::DIR_DOWN),
        .q        (remain)
    );

    assign hit = step && !load && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) tc <= 1'b0;
        else     tc <= hit;
    end
endmodule

// File: rtl/dma_agen_map.sv
module dma_agen_map #(
    parameter int CNT_W  = dma_agen_pkg::DEF_CNT_W,
    parameter int PAGE_W = dma_agen_pkg::DEF_PAGE_W
) (
    input  dma_agen_pkg::chan_kind_e  kind,
    input  logic [PAGE_W-1:0]         page,
    input  logic [CNT_W-1:0]          ctr,
    output logic [CNT_W+PAGE_W-1:0]   phys
);
    localparam int PHYS_W = CNT_W + PAGE_W;

    logic [PHYS_W-1:0] byte_form;
    logic [PHYS_W-1:0] word_form;

    assign byte_form = {page, ctr};

    generate
        if (PAGE_W > 1) begin : g_wide_page
            assign word_form = {page[PAGE_W-1:1], ctr, 1'b0};
        end else begin : g_narrow_page
            assign word_form = {ctr, 1'b0};
        end
    endgenerate

    always_comb begin
        if (kind == dma_agen_pkg::KIND_WORD) phys = word_form;
        else                                 phys = byte_form;
    end
endmodule

// File: rtl/dma_phys_addr_gen.sv
module dma_phys_addr_gen #(
    parameter int CNT_W  = dma_agen_pkg::DEF_CNT_W,
    parameter int PAGE_W = dma_agen_pkg::DEF_PAGE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    is_word,
    input  logic                    dec_mode,
    input  logic [PAGE_W-1:0]       page_in,
    input  logic                    page_load,
    input  logic [CNT_W-1:0]        addr_in,
    input  logic                    addr_load,
    input  logic [CNT_W-1:0]        cnt_in,
    input  logic                    cnt_load,
    input  logic                    xfer_done,
    output logic [CNT_W+PAGE_W-1:0] phys_addr,
    output logic                    word_size,
    output logic                    tc_pulse
);
    import dma_agen_pkg::*;

    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  addr_q;
    chan_kind_e        kind;
    step_dir_e         dir;

    assign kind = is_word  ? KIND_WORD : KIND_BYTE;
    assign dir  = dec_mode ? DIR_DOWN  : DIR_UP;

    always_ff @(posedge clk) begin
        if (rst)            page_q <= '0;
        else if (page_load) page_q <= page_in;
    end

    dma_agen_stepper #(.W(CNT_W)) i_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (addr_load),
        .load_val (addr_in),
        .step     (xfer_done),
        .dir      (dir),
        .q        (addr_q)
    );

    dma_agen_tc #(.W(CNT_W)) i_tc (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_in),
        .step     (xfer_done),
        .tc       (tc_pulse)
    );

    dma_agen_map #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) i_map (
        .kind (kind),
        .page (page_q),
        .ctr  (addr_q),
        .phys (phys_addr)
    );

    assign word_size = is_word;
endmodule

// File: rtl/dma_phys_addr_gen_chk.sv
module dma_phys_addr_gen_chk #(
    parameter int CNT_W  = 16,
    parameter int PAGE_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    is_word,
    input logic                    dec_mode,
    input logic                    page_load,
    input logic                    addr_load,
    input logic                    cnt_load,
    input logic                    xfer_done,
    input logic                    tc_pulse,
    input logic [CNT_W+PAGE_W-1:0] phys_addr,
    input logic [CNT_W-1:0]        addr_q
);
    a_r3_word_even: assert property (@(posedge clk) disable iff (rst)
        is_word |-> (phys_addr[0] == 1'b0));

    a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !addr_load && !dec_mode) |=> (addr_q == $past(addr_q) + CNT_W'(1)));

    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !addr_load && dec_mode) |=> (addr_q == $past(addr_q) - CNT_W'(1)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!xfer_done && !addr_load) |=> $stable(addr_q));

    a_r6_tc_needs_done: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_pulse) |-> ($past(xfer_done) && !$past(cnt_load)));
endmodule

bind dma_phys_addr_gen dma_phys_addr_gen_chk #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .is_word   (is_word),
    .dec_mode  (dec_mode),
    .page_load (page_load),
    .addr_load (addr_load),
    .cnt_load  (cnt_load),
    .xfer_done (xfer_done),
    .tc_pulse  (tc_pulse),
    .phys_addr (phys_addr),
    .addr_q    (addr_q)
);

// File: tb/test_dma_phys_addr_gen.sv
module test_dma_phys_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        is_word, dec_mode, page_load, addr_load, cnt_load, xfer_done;
    logic [7:0]  page_in;
    logic [15:0] addr_in, cnt_in;
    logic [23:0] phys_addr;
    logic        word_size, tc_pulse;

    int     n_vec = 0;
    int     n_bad = 0;
    int     cycles = 0;
    string  cur_req = "R1";

    logic [7:0]  m_page;
    logic [15:0] m_addr;
    logic [15:0] m_cnt;
    logic        m_tc;

    always #2 clk = ~clk;

    dma_phys_addr_gen i_dma_phys_addr_gen (
        .clk(clk), .rst(rst), .is_word(is_word), .dec_mode(dec_mode),
        .page_in(page_in), .page_load(page_load), .addr_in(addr_in),
        .addr_load(addr_load), .cnt_in(cnt_in), .cnt_load(cnt_load),
        .xfer_done(xfer_done), .phys_addr(phys_addr), .word_size(word_size),
        .tc_pulse(tc_pulse)
    );

    function automatic logic [23:0] exp_phys();
        if (is_word) return {m_page[7:1], m_addr, 1'b0};
        return {m_page, m_addr};
    endfunction

    task automatic compare();
        logic [23:0] ep;
        ep = exp_phys();
        n_vec++;
        if (phys_addr !== ep || word_size !== is_word || tc_pulse !== m_tc) begin
            n_bad++;
            $display("FAIL %s: phys=%h ws=%b tc=%b expected phys=%h ws=%b tc=%b",
                     cur_req, phys_addr, word_size, tc_pulse, ep, is_word, m_tc);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_page = '0; m_addr = '0; m_cnt = '0; m_tc = 1'b0;
        end else begin
            m_tc = xfer_done && !cnt_load && (m_cnt == 16'h0000);
            if (page_load) m_page = page_in;
            if (addr_load) m_addr = addr_in;
            else if (xfer_done) m_addr = dec_mode ? m_addr - 16'd1 : m_addr + 16'd1;
            if (cnt_load) m_cnt = cnt_in;
            else if (xfer_done) m_cnt = m_cnt - 16'd1;
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        page_load = 0; addr_load = 0; cnt_load = 0; xfer_done = 0;
    endtask

    task automatic ld_page(input logic [7:0] p);
        page_in = p; page_load = 1; cyc();
    endtask
    task automatic ld_addr(input logic [15:0] a);
        addr_in = a; addr_load = 1; cyc();
    endtask
    task automatic ld_cnt(input logic [15:0] c);
        cnt_in = c; cnt_load = 1; cyc();
    endtask
    task automatic done_n(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_done = 1; cyc();
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_bad++;
                $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        rst = 1; is_word = 0; dec_mode = 0; page_load = 0; addr_load = 0;
        cnt_load = 0; xfer_done = 0; page_in = 0; addr_in = 0; cnt_in = 0;
        @(negedge clk);
        cur_req = "R1";
        cyc(); cyc();
        page_in = 8'hFF; page_load = 1; cyc();
        rst = 0;
        cyc();

        cur_req = "R2";
        ld_page(8'h12); ld_addr(16'hABCD); cyc();

        cur_req = "R9";
        is_word = 1; cyc();
        cur_req = "R3";
        ld_page(8'h13); cyc();
        ld_page(8'h12); cyc();
        is_word = 0; cyc();

        cur_req = "R4";
        ld_addr(16'hFFFE); done_n(3); is_word = 1; done_n(2); is_word = 0;

        cur_req = "R5";
        dec_mode = 1; ld_addr(16'h0001); done_n(3); is_word = 1; done_n(1);
        is_word = 0; dec_mode = 0;

        cur_req = "R7";
        ld_addr(16'hFFFF); ld_page(8'h40); done_n(1); ld_page(8'h41); is_word = 1; cyc();
        is_word = 0;

        cur_req = "R6";
        ld_cnt(16'd3); done_n(5); cyc();
        ld_cnt(16'd0); done_n(1); cyc(); cyc();

        cur_req = "R8";
        addr_in = 16'h1234; addr_load = 1; xfer_done = 1; cyc();
        cnt_in = 16'd0; cnt_load = 1; xfer_done = 1; cyc();
        done_n(1); cyc();

        cur_req = "R10";
        for (int i = 0; i < 6; i++) cyc();

        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            is_word   = 1'($urandom);
            dec_mode  = 1'($urandom);
            page_in   = 8'($urandom);
            page_load = ($urandom % 8) == 0;
            addr_in   = ($urandom % 2) ? 16'hFFFF - 16'($urandom % 3) : 16'($urandom % 3);
            addr_load = ($urandom % 16) == 0;
            cnt_in    = 16'($urandom % 6);
            cnt_load  = ($urandom % 12) == 0;
            xfer_done = ($urandom % 3) != 0;
            cyc();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule